// File: doc/BRIEF.md
# Trailing-Edge PWM Timer with Placed Sample and Update Strobes

This block generates the gate drive of a boost converter switch with fixed-frequency, trailing-edge modulation. A free-running period counter turns the gate on at the first clock of every switching period and off once the active duty count is reached. The same counter places one ADC sample strobe per period and one update strobe. The update strobe marks the clock at which the block captures the controller's duty word and makes it the active duty.

Three timing modes choose where the sample falls and when a newly computed duty takes hold. In the pre-edge mode the sample sits a programmable distance before the turn-off edge, and the captured duty already moves that same period's turn-off edge. In the post-turn-on mode the sample sits a programmable distance after the turn-on edge, once the switching transient has died out, and the new duty governs the next period. In the late pre-edge mode the sample timing matches the pre-edge mode, but every captured duty waits one extra full period before it reaches the gate.

Duty words are limited to a legal range. A sample position that would fall within a guard band of either switching edge is moved to the nearest legal clock.

Top module: `pwm_sample_timer`

## Requirements
- R1: While reset is held and in the first clock after its release, the period counter is at cycle 0, the active duty equals DUTY_MIN, the gate is high, and both strobes are low.
- R2: Every switching period lasts exactly PERIOD clocks. The gate is high on cycle 0 and stays high until the active duty count is reached, then stays low through cycle PERIOD-1.
- R3: A duty word below DUTY_MIN is taken as DUTY_MIN and one above DUTY_MAX as DUTY_MAX. Over a whole period the gate is high for exactly the clamped active duty count.
- R4: With the mode held steady, sample_stb is high on exactly one clock per period and is never high on the same clock as update_stb.
- R5: In modes 0, 2 and 3 the sample falls on cycle D - pre_gap, where D is the active duty. If pre_gap < GUARD the sample falls on cycle D - GUARD, and if D - pre_gap < GUARD it falls on cycle GUARD.
- R6: In mode 1 the sample falls on cycle post_gap, limited to the range GUARD to D - GUARD.
- R7: A sample is never closer than GUARD clocks to the turn-on edge (cycle 0) or to the turn-off edge of the same period.
- R8: In mode 0, update_stb is high on the clock after the sample (cycle s+1). The new active duty is the larger of the clamped duty word and s+GUARD, and it sets the gate from cycle s+2 of the same period.
- R9: In mode 1, update_stb is high on cycle PERIOD-1. The clamped duty word present on that clock becomes the active duty from the next period on.
- R10: In mode 2, update_stb is high on cycle PERIOD-1 and the active duty becomes the duty word captured at the previous period boundary. The clamped duty word is captured into that one-period hold at every boundary, in every mode.
- R11: Mode code 3 behaves exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_cmd | input | CW | Duty word in clocks from the controller |
| mode_sel | input | 2 | 0 pre-edge, 1 post-turn-on, 2 late pre-edge, 3 same as 0 |
| pre_gap | input | CW | Requested sample distance before the turn-off edge |
| post_gap | input | CW | Requested sample distance after the turn-on edge |
| gate | output | 1 | Switch drive, high during the on time |
| sample_stb | output | 1 | One-clock ADC sample strobe |
| update_stb | output | 1 | One-clock strobe on which the duty word is captured |

## Verification
The bench builds the timer with a 40-clock period, a guard of 3 clocks and a duty range of 8 to 34, so the 6-bit duty and offset words span the whole code space: values below the minimum, above the maximum, and offsets that fall short of or run past the guard window on either side. At that size every mode can be run for two dozen periods with a changing duty word and changing offsets. Each clock of every period is compared against positions the bench derives from the requirements, including the pre-edge case where a short new duty is held back to the guard distance, and the one-period lag of the late mode.

// File: rtl/pwm_sample_timer.sv
module pwm_sample_timer #(
  parameter int PERIOD   = 1000,
  parameter int GUARD    = 8,
  parameter int DUTY_MIN = 40,
  parameter int DUTY_MAX = 950,
  localparam int CW      = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty_cmd,
  input  logic [1:0]    mode_sel,
  input  logic [CW-1:0] pre_gap,
  input  logic [CW-1:0] post_gap,
  output logic          gate,
  output logic          sample_stb,
  output logic          update_stb
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] G    = CW'(GUARD);
  localparam logic [CW-1:0] DMIN = CW'(DUTY_MIN);
  localparam logic [CW-1:0] DMAX = CW'(DUTY_MAX);

  logic [CW-1:0] cnt, duty_q, duty_hold;
  logic [CW-1:0] duty_lim, win_hi, pre_pos, post_pos, smp_pos, floor_a, duty_a;
  logic          smp_done, smp_d;
  logic          at_end, pre_mode;

  assign at_end   = (cnt == LAST);
  assign pre_mode = (mode_sel != 2'd1);
  assign duty_lim = (duty_cmd < DMIN) ? DMIN : (duty_cmd > DMAX) ? DMAX : duty_cmd;
  assign win_hi   = duty_q - G;

  always_comb begin
    if (pre_gap < G)           pre_pos = win_hi;
    else if (pre_gap > win_hi) pre_pos = G;
    else                       pre_pos = duty_q - pre_gap;
  end

  assign post_pos = (post_gap < G) ? G : (post_gap > win_hi) ? win_hi : post_gap;
  assign smp_pos  = pre_mode ? pre_pos : post_pos;

  assign floor_a  = cnt + CW'(GUARD - 1);
  assign duty_a   = (duty_lim > floor_a) ? duty_lim : floor_a;

  assign gate       = (cnt < duty_q);
  assign sample_stb = (cnt == smp_pos) && !smp_done;
  assign update_stb = smp_d || (at_end && (mode_sel == 2'd1 || mode_sel == 2'd2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      duty_q    <= DMIN;
      duty_hold <= DMIN;
      smp_done  <= 1'b0;
      smp_d     <= 1'b0;
    end else begin
      cnt      <= at_end ? '0 : cnt + CW'(1);
      smp_done <= at_end ? 1'b0 : (smp_done | sample_stb);
      smp_d    <= sample_stb && (mode_sel == 2'd0 || mode_sel == 2'd3);
      if (at_end) duty_hold <= duty_lim;
      if (smp_d)
        duty_q <= duty_a;
      else if (at_end && mode_sel == 2'd1)
        duty_q <= duty_lim;
      else if (at_end && mode_sel == 2'd2)
        duty_q <= duty_hold;
    end
  end

endmodule

// File: rtl/pwm_sample_timer_chk.sv
module pwm_sample_timer_chk #(
  parameter int PERIOD   = 1000,
  parameter int GUARD    = 8,
  parameter int DUTY_MIN = 40,
  parameter int DUTY_MAX = 950,
  parameter int CW       = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_sel,
  input logic          gate,
  input logic          sample_stb,
  input logic          update_stb,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] duty_q
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  assert_gate_on_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST) |=> gate);

  assert_gate_off_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST) |-> !gate);

  assert_duty_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q >= CW'(DUTY_MIN)) && (duty_q <= CW'(DUTY_MAX)));

  assert_single_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_strobes_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !update_stb);

  assert_sample_after_turn_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (gate && cnt >= CW'(GUARD)));

  assert_sample_before_turn_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> gate);

  assert_update_follows_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && (mode_sel == 2'd0 || mode_sel == 2'd3)) |=> update_stb);

endmodule

bind pwm_sample_timer pwm_sample_timer_chk #(
  .PERIOD(PERIOD), .GUARD(GUARD), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .gate(gate),
  .sample_stb(sample_stb), .update_stb(update_stb), .cnt(cnt), .duty_q(duty_q)
);

// File: tb/test_pwm_sample_timer.sv
module test_pwm_sample_timer;
  localparam int P    = 40;
  localparam int G    = 3;
  localparam int DMIN = 8;
  localparam int DMAX = 34;
  localparam int CW   = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] duty_cmd = '0;
  logic [CW-1:0] pre_gap = '0;
  logic [CW-1:0] post_gap = '0;
  logic [1:0]    mode_sel = 2'd0;
  logic          gate, sample_stb, update_stb;

  int n_cmp = 0;
  int n_bad = 0;
  int dcur = DMIN;
  int hold = DMIN;

  always #4 clk = ~clk;

  pwm_sample_timer #(.PERIOD(P), .GUARD(G), .DUTY_MIN(DMIN), .DUTY_MAX(DMAX)) i_pwm_sample_timer (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .mode_sel(mode_sel),
    .pre_gap(pre_gap), .post_gap(post_gap),
    .gate(gate), .sample_stb(sample_stb), .update_stb(update_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int lim(input int d);
    return (d < DMIN) ? DMIN : (d > DMAX) ? DMAX : d;
  endfunction

  task automatic run_period(input int m, input int duty, input int pre, input int post);
    int s, dn, dna, hi, scount, spos, offk, hicnt;
    bit pre_m, eg, es, eu;
    string tg, ts;
    pre_m = (m != 1);
    dn = lim(duty);
    hi = dcur - G;
    if (pre_m) s = (pre < G) ? hi : (pre > hi) ? G : dcur - pre;
    else       s = (post < G) ? G : (post > hi) ? hi : post;
    dna = (dn > s + G) ? dn : s + G;
    tg = (m == 0) ? "R8" : (m == 1) ? "R9" : (m == 2) ? "R10" : "R11";
    ts = (m == 1) ? "R6" : (m == 3) ? "R11" : "R5";
    scount = 0; spos = -1; offk = P; hicnt = 0;
    for (int k = 0; k < P; k++) begin
      if (k == 0) begin
        mode_sel = 2'(m);
        duty_cmd = CW'(duty);
        pre_gap  = CW'(pre);
        post_gap = CW'(post);
      end else begin
        @(negedge clk);
      end
      #1;
      if (pre_m && m != 2 && k >= s + 2) eg = (k < dna);
      else                               eg = (k < dcur);
      es = (k == s);
      eu = (pre_m && m != 2) ? (k == s + 1) : (k == P - 1);
      if (k == 0 || k == P - 1) chk(gate == eg, "R2 gate", gate, eg);
      else                      chk(gate == eg, {tg, " gate"}, gate, eg);
      chk(sample_stb == es, {ts, " sample"}, sample_stb, es);
      chk(update_stb == eu, {tg, " update"}, update_stb, eu);
      if (sample_stb) begin scount++; spos = k; end
      if (sample_stb && update_stb) scount += 100;
      if (gate) hicnt++;
      else if (offk == P) offk = k;
    end
    chk(scount == 1, "R4 samples per period", scount, 1);
    chk(spos >= G && offk - spos >= G, "R7 guard distance", offk - spos, G);
    if (pre_m && m != 2) begin
      chk(hicnt == dna, {tg, " on-time"}, hicnt, dna);
      dcur = dna;
    end else begin
      chk(hicnt == dcur, "R3 on-time", hicnt, dcur);
      dcur = (m == 1) ? dn : hold;
    end
    hold = dn;
  endtask

  initial begin
    #1600000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(gate == 1'b1 && sample_stb == 1'b0 && update_stb == 1'b0, "R1 in reset",
        {gate, sample_stb, update_stb}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(gate == 1'b1 && sample_stb == 1'b0 && update_stb == 1'b0, "R1 after release",
        {gate, sample_stb, update_stb}, 3'b100);
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 24; i++) begin
        run_period(m, (i * 7 + m * 5) % 64, (i * 3) % 20, (i * 5 + 1) % 40);
        @(negedge clk);
      end
    end
    for (int i = 0; i < 12; i++) begin
      run_period(i % 3, (i * 13 + 2) % 64, 40 - i, (i * 11) % 64);
      @(negedge clk);
    end
    finish_run();
  end

endmodule